// File: doc/BRIEF.md
# Redundant Check Event Filter

This block sits in the path of monitoring check events and removes those whose result is already known. Each incoming event carries a byte address and an access kind, load or store. The block keeps a small set-associative cache of event keys that were recently delivered. An event whose key is already in the cache has an outcome that cannot have changed, so it is dropped. Any other event is passed on and its key is recorded.

Software raises an invalidate strobe on events that can change the checked state, such as a deallocation or a synchronization point. The strobe empties the whole cache in a single cycle.

A mode input selects how keys compare. In address-check mode the access kind does not take part, so a load and a store to the same word match each other. In lock-discipline mode the kind is part of the key, so the first load and the first store to a word are both delivered. Within a set, replacement evicts the least recently used way. Every result appears one cycle after its event. It is either a delivered event on the output stream or a one-cycle dropped pulse.

Top module: `idem_filter`

## Requirements
- R1: During reset and in the first cycle after reset, both outputs stay low and the cache holds no keys, so the first event after reset is delivered.
- R2: An event whose key is not in the cache is delivered one cycle later. `dlv_valid` is high, `dlv_addr` and `dlv_is_store` equal the event's address and kind, and `drop_flag` is low. The key is then recorded.
- R3: An event whose key is in the cache gives `drop_flag` high and `dlv_valid` low one cycle later.
- R4: The key holds the word address, which is address bits 31:2. Bits 1:0 are ignored, so any two byte addresses within one 4-byte word match.
- R5: With `lock_mode` = 0 (address-check), the access kind (`evt_is_store`: 0 = load, 1 = store) is ignored in the comparison. A store then matches a recorded load to the same word, and a load matches a recorded store.
- R6: With `lock_mode` = 1 (lock-discipline), load and store are separate keys. The first load and the first store to a word are each delivered, and later repeats of either are dropped.
- R7: A cycle with `inval` high removes every recorded key, so every event after it is delivered until its key is recorded again.
- R8: An event in the same cycle as `inval` is delivered and its key is not recorded. An identical event in the next cycle is delivered again.
- R9: The cache has NUM_SETS = ENTRIES/WAYS sets, indexed by word-address bits [log2(NUM_SETS)-1:0] (address bits 5:2 at the default 64 entries and 4 ways). Up to WAYS keys with the same set index coexist. A new key in a full set replaces the key used least recently, where both hits and inserts count as uses.
- R10: In a cycle with no event, the next cycle has `dlv_valid` and `drop_flag` both low. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_mode | input | 1 | 0 = address-check keys, 1 = lock-discipline keys |
| evt_valid | input | 1 | Check event present |
| evt_addr | input | 32 | Byte address of the event |
| evt_is_store | input | 1 | Access kind, 0 = load, 1 = store |
| inval | input | 1 | Empty the cache this cycle |
| dlv_valid | output | 1 | Delivered event valid |
| dlv_addr | output | 32 | Address of delivered event |
| dlv_is_store | output | 1 | Kind of delivered event |
| drop_flag | output | 1 | Event of previous cycle was dropped |

## Verification
The bench drives the worst-case replacement pattern: five words that share one set. This shows whether the evicted way is the least recently used one, and a design that refreshed recency only on inserts, or picked a fixed way, would drop the wrong key. It places events in the same cycle as invalidation and right after it. A design that recorded such an event would drop its immediate repeat, and one that ignored the strobe would keep filtering. It also pairs loads and stores to one word in both modes. Comparing the kind in address-check mode, or ignoring it in lock mode, shows up as an unexpected delivery or an unexpected drop. Byte offsets inside a word are varied to catch an index or tag taken from the wrong address bits.

// File: rtl/idf_pkg.sv
package idf_pkg;

    localparam int ADDR_W = 32;
    localparam int OFFS_W = 2;
    localparam int WORD_W = ADDR_W - OFFS_W;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } kind_e;

    typedef enum logic {
        MODE_ADDR = 1'b0,
        MODE_LOCK = 1'b1
    } mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        kind_e             kind;
    } key_t;

    typedef struct packed {
        logic vld;
        key_t key;
    } entry_t;

    function automatic key_t make_key(logic [ADDR_W-1:0] addr, kind_e kind);
        key_t k;
        k.word = addr[ADDR_W-1:OFFS_W];
        k.kind = kind;
        return k;
    endfunction

    function automatic logic key_hit(entry_t e, key_t k, mode_e m);
        return e.vld && (e.key.word == k.word) &&
               ((m == MODE_ADDR) || (e.key.kind == k.kind));
    endfunction

endpackage

// File: rtl/idf_store.sv
module idf_store
    import idf_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int IDX_W = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic [IDX_W-1:0]           set_idx,
    input  logic                       upd_en,
    input  logic [WAYS-1:0][AGE_W-1:0] upd_ages,
    input  logic                       fill_en,
    input  logic [WAY_W-1:0]           fill_way,
    input  key_t                       fill_key,
    output entry_t [WAYS-1:0]          rd_row,
    output logic [WAYS-1:0][AGE_W-1:0] rd_ages
);

    entry_t           row_q [SETS][WAYS];
    logic [AGE_W-1:0] age_q [SETS][WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_row[w]  = row_q[set_idx][w];
            rd_ages[w] = age_q[set_idx][w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    row_q[s][w].vld <= 1'b0;
                    age_q[s][w]     <= AGE_W'(w);
                end
            end
        end else begin
            if (upd_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[set_idx][w] <= upd_ages[w];
                end
            end
            if (fill_en) begin
                row_q[set_idx][fill_way].vld <= 1'b1;
                row_q[set_idx][fill_way].key <= fill_key;
            end
        end
    end

endmodule

// File: rtl/idf_match.sv
module idf_match
    import idf_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input  entry_t [WAYS-1:0]          row,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    input  key_t                       key,
    input  mode_e                      mode,
    output logic                       hit,
    output logic [WAY_W-1:0]           victim_way,
    output logic [WAYS-1:0][AGE_W-1:0] new_ages
);

    logic             have_free;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic [WAY_W-1:0] touch_way;
    logic [AGE_W-1:0] pivot;

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && key_hit(row[w], key, mode)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end

        have_free = 1'b0;
        free_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!have_free && !row[w].vld) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end

        old_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == AGE_W'(WAYS - 1)) begin
                old_way = WAY_W'(w);
            end
        end

        victim_way = have_free ? free_way : old_way;
        touch_way  = hit ? hit_way : victim_way;
        pivot      = ages[touch_way];

        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                new_ages[w] = '0;
            end else if (ages[w] < pivot) begin
                new_ages[w] = ages[w] + AGE_W'(1);
            end else begin
                new_ages[w] = ages[w];
            end
        end
    end

endmodule

// File: rtl/idem_filter.sv
module idem_filter
    import idf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WAYS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_mode,
    input  logic              evt_valid,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              evt_is_store,
    input  logic              inval,
    output logic              dlv_valid,
    output logic [ADDR_W-1:0] dlv_addr,
    output logic              dlv_is_store,
    output logic              drop_flag
);

    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int AGE_W = WAY_W;

    key_t                       cur_key;
    mode_e                      cur_mode;
    logic [IDX_W-1:0]           cur_set;
    entry_t [WAYS-1:0]          row;
    logic [WAYS-1:0][AGE_W-1:0] ages;
    logic [WAYS-1:0][AGE_W-1:0] next_ages;
    logic                       hit;
    logic [WAY_W-1:0]           victim;
    logic                       accept;

    assign cur_key  = make_key(evt_addr, kind_e'(evt_is_store));
    assign cur_mode = mode_e'(lock_mode);
    assign cur_set  = cur_key.word[IDX_W-1:0];
    assign accept   = evt_valid && !inval;

    idf_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W),
        .AGE_W (AGE_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clear    (inval),
        .set_idx  (cur_set),
        .upd_en   (accept),
        .upd_ages (next_ages),
        .fill_en  (accept && !hit),
        .fill_way (victim),
        .fill_key (cur_key),
        .rd_row   (row),
        .rd_ages  (ages)
    );

    idf_match #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W),
        .AGE_W (AGE_W)
    ) u_match (
        .row        (row),
        .ages       (ages),
        .key        (cur_key),
        .mode       (cur_mode),
        .hit        (hit),
        .victim_way (victim),
        .new_ages   (next_ages)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid    <= 1'b0;
            drop_flag    <= 1'b0;
            dlv_addr     <= '0;
            dlv_is_store <= 1'b0;
        end else begin
            dlv_valid <= evt_valid && (inval || !hit);
            drop_flag <= accept && hit;
            if (evt_valid) begin
                dlv_addr     <= evt_addr;
                dlv_is_store <= evt_is_store;
            end
        end
    end

endmodule

// File: rtl/idf_checker.sv
module idf_checker (
    input logic        clk,
    input logic        rst,
    input logic        lock_mode,
    input logic        evt_valid,
    input logic [31:0] evt_addr,
    input logic        evt_is_store,
    input logic        inval,
    input logic        dlv_valid,
    input logic [31:0] dlv_addr,
    input logic        dlv_is_store,
    input logic        drop_flag
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(dlv_valid && drop_flag)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> (!dlv_valid && !drop_flag)); // R10

    AST_EVENT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> (dlv_valid || drop_flag)); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (dlv_addr == $past(evt_addr) &&
                       dlv_is_store == $past(evt_is_store))); // R2

    AST_INVAL_DELIVERS: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && inval) |=> dlv_valid); // R8

    AST_AFTER_INVAL: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && $past(inval) && !$past(rst)) |=> dlv_valid); // R7

    AST_REPEAT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !inval && $past(evt_valid) && !$past(inval) && !$past(rst) &&
         evt_addr[31:2] == $past(evt_addr[31:2]) &&
         evt_is_store == $past(evt_is_store) &&
         lock_mode == $past(lock_mode)) |=> drop_flag); // R3

endmodule

bind idem_filter idf_checker u_idf_checker (
    .clk          (clk),
    .rst          (rst),
    .lock_mode    (lock_mode),
    .evt_valid    (evt_valid),
    .evt_addr     (evt_addr),
    .evt_is_store (evt_is_store),
    .inval        (inval),
    .dlv_valid    (dlv_valid),
    .dlv_addr     (dlv_addr),
    .dlv_is_store (dlv_is_store),
    .drop_flag    (drop_flag)
);

// File: tb/test_idem_filter.sv
module test_idem_filter;

    localparam int ENTRIES = 64;
    localparam int WAYS    = 4;
    localparam int SETS    = ENTRIES / WAYS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_mode = 1'b0;
    logic        evt_valid = 1'b0;
    logic [31:0] evt_addr = '0;
    logic        evt_is_store = 1'b0;
    logic        inval = 1'b0;
    logic        dlv_valid;
    logic [31:0] dlv_addr;
    logic        dlv_is_store;
    logic        drop_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [29:0] m_word [SETS][WAYS];
    logic        m_kind [SETS][WAYS];
    int          m_cnt  [SETS];

    always #4 clk = ~clk;

    idem_filter #(.ENTRIES(ENTRIES), .WAYS(WAYS)) i_idem_filter (
        .clk          (clk),
        .rst          (rst),
        .lock_mode    (lock_mode),
        .evt_valid    (evt_valid),
        .evt_addr     (evt_addr),
        .evt_is_store (evt_is_store),
        .inval        (inval),
        .dlv_valid    (dlv_valid),
        .dlv_addr     (dlv_addr),
        .dlv_is_store (dlv_is_store),
        .drop_flag    (drop_flag)
    );

    // Recency-ordered reference: index 0 is most recent in each set.
    task automatic model_clear();
        for (int s = 0; s < SETS; s++) m_cnt[s] = 0;
    endtask

    task automatic model_event(input logic [31:0] a, input bit st, output bit deliver);
        logic [29:0] w;
        int s;
        int pos;
        int n;
        logic [29:0] tw;
        logic tk;
        w   = a[31:2];
        s   = int'(w % SETS);
        pos = -1;
        for (int i = 0; i < m_cnt[s]; i++) begin
            if (pos < 0 && m_word[s][i] == w && (!lock_mode || m_kind[s][i] == st)) pos = i;
        end
        if (pos >= 0) begin
            tw = m_word[s][pos];
            tk = m_kind[s][pos];
            for (int j = pos; j > 0; j--) begin
                m_word[s][j] = m_word[s][j-1];
                m_kind[s][j] = m_kind[s][j-1];
            end
            m_word[s][0] = tw;
            m_kind[s][0] = tk;
            deliver = 0;
        end else begin
            n = (m_cnt[s] < WAYS) ? m_cnt[s] + 1 : WAYS;
            for (int j = n - 1; j > 0; j--) begin
                m_word[s][j] = m_word[s][j-1];
                m_kind[s][j] = m_kind[s][j-1];
            end
            m_word[s][0] = w;
            m_kind[s][0] = st;
            m_cnt[s]     = n;
            deliver = 1;
        end
    endtask

    // Called at a falling edge; checks at the next falling edge.
    task automatic do_evt(input bit v, input logic [31:0] a, input bit st,
                          input bit inv, input string tag);
        bit ed;
        bit ep;
        bit dl;
        ed = 0;
        ep = 0;
        if (v && inv) begin
            ed = 1;
        end else if (v) begin
            model_event(a, st, dl);
            ed = dl;
            ep = !dl;
        end
        if (inv) model_clear();
        evt_valid    = v;
        evt_addr     = a;
        evt_is_store = st;
        inval        = inv;
        @(negedge clk);
        evt_valid = 0;
        inval     = 0;
        n_chk++;
        if (dlv_valid !== ed || drop_flag !== ep ||
            (ed && (dlv_addr !== a || dlv_is_store !== st))) begin
            n_err++;
            $display("FAIL %s: dlv=%0b drop=%0b addr=%h st=%0b expected dlv=%0b drop=%0b addr=%h st=%0b",
                     tag, dlv_valid, drop_flag, dlv_addr, dlv_is_store, ed, ep, a, st);
        end
    endtask

    function automatic logic [31:0] set_addr(int set, int k, int off);
        return 32'((((k * SETS) + set) << 2) + off);
    endfunction

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4711);
        model_clear();
        repeat (3) @(negedge clk);
        n_chk++;
        if (dlv_valid !== 1'b0 || drop_flag !== 1'b0) begin
            n_err++;
            $display("FAIL R1: dlv=%0b drop=%0b expected 0 0", dlv_valid, drop_flag);
        end
        rst = 0;
        @(negedge clk);
        n_chk++;
        if (dlv_valid !== 1'b0 || drop_flag !== 1'b0) begin
            n_err++;
            $display("FAIL R1: dlv=%0b drop=%0b after reset expected 0 0", dlv_valid, drop_flag);
        end

        // address-check mode
        lock_mode = 0;
        do_evt(1, 32'h0000_0100, 0, 0, "R1 first event");
        do_evt(1, 32'h0000_0100, 0, 0, "R3 repeat");
        do_evt(1, 32'h0000_0103, 0, 0, "R4 byte offset");
        do_evt(1, 32'h0000_0104, 0, 0, "R2 next word");
        do_evt(1, 32'h0000_0101, 1, 0, "R5 store matches load");
        do_evt(1, 32'h0000_0500, 1, 0, "R2 store miss");
        do_evt(1, 32'h0000_0502, 0, 0, "R5 load matches store");
        do_evt(0, 32'h0, 0, 0, "R10 idle");
        do_evt(0, 32'h0, 0, 1, "R7 strobe alone");
        do_evt(1, 32'h0000_0100, 0, 0, "R7 cleared");
        do_evt(1, 32'h0000_0500, 1, 0, "R7 cleared store");
        do_evt(1, 32'h0000_0200, 0, 1, "R8 event with strobe");
        do_evt(1, 32'h0000_0200, 0, 0, "R8 not recorded");
        do_evt(1, 32'h0000_0200, 0, 0, "R3 now recorded");

        // lock-discipline mode
        do_evt(0, 32'h0, 0, 1, "R7 mode switch");
        lock_mode = 1;
        do_evt(1, 32'h0000_0300, 0, 0, "R6 first load");
        do_evt(1, 32'h0000_0301, 1, 0, "R6 first store");
        do_evt(1, 32'h0000_0302, 0, 0, "R6 load repeat");
        do_evt(1, 32'h0000_0300, 1, 0, "R6 store repeat");

        // replacement within one set
        do_evt(0, 32'h0, 0, 1, "R7 before R9");
        lock_mode = 0;
        for (int k = 0; k < 4; k++) do_evt(1, set_addr(5, k, k % 4), 0, 0, "R9 fill");
        for (int k = 0; k < 4; k++) do_evt(1, set_addr(5, k, 0), 0, 0, "R9 all resident");
        do_evt(1, set_addr(5, 0, 2), 1, 0, "R9 refresh way");
        do_evt(1, set_addr(5, 4, 0), 0, 0, "R9 fifth key");
        do_evt(1, set_addr(5, 0, 0), 0, 0, "R9 refreshed survives");
        do_evt(1, set_addr(5, 1, 0), 0, 0, "R9 LRU evicted");
        do_evt(1, set_addr(6, 0, 0), 0, 0, "R9 other set");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            if (i % 500 == 0) begin
                do_evt(0, 32'h0, 0, 1, "R7 mode switch");
                lock_mode = ($urandom % 2) == 1;
            end
            a = {2'b00, 28'($urandom % 96), 2'($urandom % 4)};
            do_evt(($urandom % 8) != 0, a, ($urandom % 2) == 1,
                   ($urandom % 40) == 0, "R9 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule